// File: doc/BRIEF.md
# Hot-Plug Slot Control and Status Registers

This block is the register logic on the slot side of a hot-pluggable expansion slot. Software reaches a 16-bit control register and a 16-bit status register through a plain register port. The port has a write strobe, a register select and two byte enables, and read data is combinational. The block takes in debounced slot signals: attention button, presence detect, retention latch sensor, power fault and interlock state. It drives slot power enable, the two indicator fields and a one-cycle interlock toggle pulse.

Slot events are latched into status bits. Software clears each one by writing 1 to it. Every accepted write to the control register starts a timed command. When the command finishes, a command-completed status bit is set. A level interrupt is high while any enabled event is pending and the master enable is set.

Top module: `hp_slot_regs`

## Requirements
- R1: After reset the control register reads 0x07C0, which means both indicators are off (11), slot power is off (bit 10 = 1) and all enables are 0. Status bits 0 to 4 read 0 and pwr_en_o is 0.
- R2: Status bit 0 sets on a rising edge of btn_i and bit 1 sets on a rising edge of pwr_fault_i. Bit 2 sets on any change of latch_i and bit 3 sets on any change of prsnt_i. Each bit sets at the first clock edge where the input differs from its value at the previous edge. Falling edges of btn_i and pwr_fault_i set nothing.
- R3: A status write (reg_sel_i = 1) with reg_be_i[0] = 1 clears each of bits 0 to 4 written as 1 and leaves bits written as 0 unchanged. If an event sets a bit in the same cycle that a write clears it, the bit stays set.
- R4: Status bits 5, 6 and 7 read live latch_i, prsnt_i and emi_state_i. Bits 15:8 read 0. A status write with only reg_be_i[1] set changes nothing.
- R5: A control write (reg_sel_i = 0) loads bits 7:0 when reg_be_i[0] = 1 and bits 10:8 when reg_be_i[1] = 1. Bits 15:11 always read 0, and the register holds its value when not written.
- R6: attn_ind_o follows control bits 7:6, pwr_ind_o follows bits 9:8, and pwr_en_o is the inverse of bit 10 (0 = power on).
- R7: A control write with reg_be_i[1] = 1 and data bit 11 = 1 makes emi_pulse_o high for exactly the one cycle after the write edge.
- R8: Status bit 4 sets exactly CMD_LAT clock edges after the edge of a control write with at least one byte enable. A control write with no byte enable starts no command.
- R9: A control write made while a command is still pending restarts the CMD_LAT count, and only one completion follows.
- R10: irq_o is high exactly when control bit 5 is 1 and either some status bit k in 0..3 is set together with control bit k, or status bit 4 is set together with control bit 4.
- R11: A latched power fault (status bit 1) survives turning slot power off and clears only by a write-1 to status bit 1.
- R12: Inputs that are already high when reset is released do not cause change events at the first edge after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 control, 1 status |
| reg_be_i | input | 2 | Byte enables: bit 0 for bits 7:0, bit 1 for bits 15:8 |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data of the selected register |
| btn_i | input | 1 | Attention button, debounced |
| pwr_fault_i | input | 1 | Power fault indication |
| latch_i | input | 1 | Retention latch sensor state |
| prsnt_i | input | 1 | Presence detect state |
| emi_state_i | input | 1 | Interlock engaged state |
| pwr_en_o | output | 1 | Slot power enable, high = on |
| attn_ind_o | output | 2 | Attention indicator: 01 on, 10 blink, 11 off |
| pwr_ind_o | output | 2 | Power indicator: 01 on, 10 blink, 11 off |
| emi_pulse_o | output | 1 | One-cycle interlock toggle pulse |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench targets the completion count at its exact cycle. A count that is off by one, or that does not restart on a second write, sets bit 4 one edge early or late, or sets it twice. It also drives an event edge into the same cycle as a write-1 clear. A design that lets the clear win would lose that event. Other targets are a power fault that survives power-off, inputs that are high across reset release, falling button edges, and writes with missing byte enables. A design that gets these wrong shows a spurious event, a lost fault, or a register field changed by a lane that was not enabled.

// File: rtl/hp_slot_pkg.sv
package hp_slot_pkg;
  localparam int REG_W     = 16;
  localparam int CTRL_BITS = 11;
  localparam int NUM_CHG   = 4;
  localparam int NUM_ST    = NUM_CHG + 1;

  // status event positions
  localparam int ST_BTN = 0;
  localparam int ST_PF  = 1;
  localparam int ST_LAT = 2;
  localparam int ST_PRS = 3;
  localparam int ST_CC  = 4;

  // control positions
  localparam int C_CC_IE  = 4;
  localparam int C_HP_IE  = 5;
  localparam int C_ATTN   = 6;
  localparam int C_PIND   = 8;
  localparam int C_PWR    = 10;
  localparam int C_EMI    = 11;

  typedef enum logic [1:0] {
    IND_RSVD  = 2'b00,
    IND_ON    = 2'b01,
    IND_BLINK = 2'b10,
    IND_OFF   = 2'b11
  } ind_e;

  localparam logic [CTRL_BITS-1:0] CTRL_RST =
    CTRL_BITS'({1'b1, IND_OFF, IND_OFF, 6'b0});
endpackage

// File: rtl/hp_edge_det.sv
module hp_edge_det #(
  parameter int W = 4,
  parameter logic [W-1:0] RISE_ONLY = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sig_i,
  output logic [W-1:0] chg_o
);
  logic [W-1:0] prev_q;
  logic         armed_q;

  // first edge after reset only captures the inputs
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      prev_q  <= sig_i;
      armed_q <= 1'b1;
    end
  end

  for (genvar g = 0; g < W; g++) begin : g_bit
    if (RISE_ONLY[g]) begin : g_rise
      assign chg_o[g] = armed_q & sig_i[g] & ~prev_q[g];
    end else begin : g_any
      assign chg_o[g] = armed_q & (sig_i[g] ^ prev_q[g]);
    end

    AST_EDGE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (armed_q && $stable(sig_i[g])) |-> !chg_o[g]); // R2
  end
endmodule

// File: rtl/hp_w1c_bits.sv
module hp_w1c_bits #(
  parameter int W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;

  // set has priority so no event is lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= (q_q & ~clr_i) | set_i;
  end

  assign q_o = q_q;

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((q_o & $past(set_i)) == $past(set_i))); // R3

  AST_CLR_ONLY_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~q_o & $past(q_o) & ~$past(clr_i)) == '0)); // R11
endmodule

// File: rtl/hp_cmd_timer.sv
module hp_cmd_timer #(
  parameter int LAT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic done_o
);
  localparam int CW = $clog2(LAT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (start_i)           cnt_q <= CW'(LAT);
    else if (cnt_q != '0)       cnt_q <= cnt_q - CW'(1);
  end

  // a restart in the last cycle cancels the pending completion
  assign done_o = (cnt_q == CW'(1)) & ~start_i;

  AST_LOAD_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (cnt_q == CW'(LAT))); // R9

  AST_COUNT_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CW'(1))); // R8
endmodule

// File: rtl/hp_slot_regs.sv
module hp_slot_regs
  import hp_slot_pkg::*;
#(
  parameter int CMD_LAT = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_wr_i,
  input  logic        reg_sel_i,
  input  logic [1:0]  reg_be_i,
  input  logic [15:0] reg_wdata_i,
  output logic [15:0] reg_rdata_o,
  input  logic        btn_i,
  input  logic        pwr_fault_i,
  input  logic        latch_i,
  input  logic        prsnt_i,
  input  logic        emi_state_i,
  output logic        pwr_en_o,
  output logic [1:0]  attn_ind_o,
  output logic [1:0]  pwr_ind_o,
  output logic        emi_pulse_o,
  output logic        irq_o
);
  logic [CTRL_BITS-1:0] ctrl_q;
  logic                 emi_q;
  logic                 ctrl_wr, stat_wr;
  logic [NUM_CHG-1:0]   chg;
  logic                 cmd_done;
  logic [NUM_ST-1:0]    st_set, st_clr, st_q;
  logic                 unused_wdata;

  assign ctrl_wr = reg_wr_i & ~reg_sel_i & (|reg_be_i);
  assign stat_wr = reg_wr_i &  reg_sel_i & reg_be_i[0];
  assign unused_wdata = ^reg_wdata_i[15:12];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CTRL_RST;
      emi_q  <= 1'b0;
    end else begin
      emi_q <= ctrl_wr & reg_be_i[1] & reg_wdata_i[C_EMI];
      if (ctrl_wr && reg_be_i[0]) ctrl_q[7:0]            <= reg_wdata_i[7:0];
      if (ctrl_wr && reg_be_i[1]) ctrl_q[CTRL_BITS-1:8]  <= reg_wdata_i[CTRL_BITS-1:8];
    end
  end

  hp_edge_det #(
    .W         (NUM_CHG),
    .RISE_ONLY (4'b0011)
  ) i_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  ({prsnt_i, latch_i, pwr_fault_i, btn_i}),
    .chg_o  (chg)
  );

  hp_cmd_timer #(
    .LAT (CMD_LAT)
  ) i_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (ctrl_wr),
    .done_o  (cmd_done)
  );

  assign st_set = {cmd_done, chg};
  assign st_clr = stat_wr ? reg_wdata_i[NUM_ST-1:0] : '0;

  hp_w1c_bits #(
    .W (NUM_ST)
  ) i_status (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (st_set),
    .clr_i  (st_clr),
    .q_o    (st_q)
  );

  always_comb begin
    if (reg_sel_i)
      reg_rdata_o = {8'h00, emi_state_i, prsnt_i, latch_i, st_q};
    else
      reg_rdata_o = {{(REG_W-CTRL_BITS){1'b0}}, ctrl_q};
  end

  assign irq_o = ctrl_q[C_HP_IE] &
                 ((|(st_q[NUM_CHG-1:0] & ctrl_q[NUM_CHG-1:0])) |
                  (st_q[ST_CC] & ctrl_q[C_CC_IE]));

  assign pwr_en_o    = ~ctrl_q[C_PWR];
  assign attn_ind_o  = ctrl_q[C_ATTN+1:C_ATTN];
  assign pwr_ind_o   = ctrl_q[C_PIND+1:C_PIND];
  assign emi_pulse_o = emi_q;

  AST_CC_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_done |=> st_q[ST_CC]); // R8

  AST_CTRL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_wr |=> $stable(ctrl_q)); // R5

  AST_PWR_FOLLOWS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && reg_be_i[1]) |=> (pwr_en_o == !$past(reg_wdata_i[C_PWR]))); // R6

  AST_IRQ_NEEDS_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (ctrl_q[C_HP_IE] && st_q != '0)); // R10

  AST_EMI_FROM_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && reg_be_i[1] && reg_wdata_i[C_EMI]) |=> emi_pulse_o); // R7
endmodule

// File: tb/test_hp_slot_regs.sv
module test_hp_slot_regs;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_sel = 1'b0;
  logic [1:0]  reg_be = 2'b00;
  logic [15:0] reg_wd = '0;
  logic [15:0] reg_rd;
  logic        btn = 0, pf = 0, lat = 0, prs = 1, emi_st = 0;
  logic        pwr_en, emi_pulse, irq;
  logic [1:0]  attn_ind, pwr_ind;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hp_slot_regs #(.CMD_LAT(LAT)) i_hp_slot_regs (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_sel_i(reg_sel),
    .reg_be_i(reg_be), .reg_wdata_i(reg_wd), .reg_rdata_o(reg_rd),
    .btn_i(btn), .pwr_fault_i(pf), .latch_i(lat), .prsnt_i(prs),
    .emi_state_i(emi_st), .pwr_en_o(pwr_en), .attn_ind_o(attn_ind),
    .pwr_ind_o(pwr_ind), .emi_pulse_o(emi_pulse), .irq_o(irq)
  );

  // reference model built from the requirements
  logic [10:0] m_ctrl;
  logic [4:0]  m_st;
  logic [3:0]  m_prev;
  logic        m_armed, m_emi;
  int          m_cnt;
  logic [3:0]  m_chg;
  logic        m_cwr, m_done;

  assign m_chg = {4{m_armed}} & {prs ^ m_prev[3], lat ^ m_prev[2],
                                 pf & ~m_prev[1], btn & ~m_prev[0]};
  assign m_cwr  = reg_wr & ~reg_sel & (|reg_be);
  assign m_done = (m_cnt == 1) && !m_cwr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl <= 11'h7C0; m_st <= '0; m_prev <= '0; m_armed <= 0;
      m_emi <= 0; m_cnt <= 0;
    end else begin
      m_prev  <= {prs, lat, pf, btn};
      m_armed <= 1'b1;
      m_cnt   <= m_cwr ? LAT : (m_cnt > 0 ? m_cnt - 1 : 0);
      m_st    <= (m_st & ~((reg_wr && reg_sel && reg_be[0]) ? reg_wd[4:0] : 5'h0))
                 | {m_done, m_chg};
      m_emi   <= m_cwr & reg_be[1] & reg_wd[11];
      if (m_cwr && reg_be[0]) m_ctrl[7:0]  <= reg_wd[7:0];
      if (m_cwr && reg_be[1]) m_ctrl[10:8] <= reg_wd[10:8];
    end
  end

  function automatic logic exp_irq(logic [10:0] c, logic [4:0] s);
    return c[5] & ((|(s[3:0] & c[3:0])) | (s[4] & c[4]));
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic rd(input logic sel, output logic [15:0] v);
    reg_sel = sel; #1; v = reg_rd;
  endtask

  task automatic compare_all();
    logic [15:0] v;
    rd(1'b0, v); chk("R5 control readback", v, {5'h0, m_ctrl});
    rd(1'b1, v); chk("R2 status readback", v, {8'h0, emi_st, prs, lat, m_st});
    chk("R10 irq", 16'(irq), 16'(exp_irq(m_ctrl, m_st)));
    chk("R6 outputs", {11'h0, pwr_en, attn_ind, pwr_ind},
        {11'h0, ~m_ctrl[10], m_ctrl[7:6], m_ctrl[9:8]});
    chk("R7 emi pulse", 16'(emi_pulse), 16'(m_emi));
    reg_sel = 1'b0;
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk); compare_all();
    end
  endtask

  task automatic wr_reg(input logic sel, input logic [1:0] be, input logic [15:0] d);
    reg_sel = sel; reg_be = be; reg_wd = d; reg_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
    compare_all();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual hung run, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [31:0] seed_dummy;
    seed_dummy = $urandom(32'h5107_C0DE);
    repeat (3) @(negedge clk);
    // R1 reset state, with prsnt high across release
    rd(1'b0, v); chk("R1 control reset", v, 16'h07C0);
    rd(1'b1, v); chk("R1 status reset", v, 16'h0040);
    chk("R1 power off", 16'(pwr_en), 16'h0);
    rst_n = 1'b1;
    tick(2);
    rd(1'b1, v); chk("R12 no change event at release", v & 16'h0008, 16'h0000);

    // R8 completion timing
    wr_reg(1'b0, 2'b11, 16'h0030);
    tick(LAT - 1);
    rd(1'b1, v); chk("R8 not yet complete", v & 16'h0010, 16'h0000);
    tick(1);
    rd(1'b1, v); chk("R8 complete at CMD_LAT", v & 16'h0010, 16'h0010);
    chk("R10 irq on completion", 16'(irq), 16'h1);
    chk("R6 power on", 16'(pwr_en), 16'h1);

    // R3 write-1 clear
    wr_reg(1'b1, 2'b01, 16'h0010);
    rd(1'b1, v); chk("R3 cc cleared", v & 16'h0010, 16'h0000);
    chk("R10 irq falls", 16'(irq), 16'h0);

    // R9 restart
    wr_reg(1'b0, 2'b01, 16'h0030);
    tick(10);
    wr_reg(1'b0, 2'b01, 16'h0030);
    tick(LAT - 1);
    rd(1'b1, v); chk("R9 restart delays completion", v & 16'h0010, 16'h0000);
    tick(1);
    rd(1'b1, v); chk("R9 single completion", v & 16'h0010, 16'h0010);
    wr_reg(1'b1, 2'b01, 16'h0010);

    // R8 write without byte enables
    wr_reg(1'b0, 2'b00, 16'h0FFF);
    tick(LAT + 4);
    rd(1'b1, v); chk("R8 no command without be", v & 16'h0010, 16'h0000);

    // R7 interlock pulse, R5 bit 11 reads 0
    wr_reg(1'b0, 2'b10, 16'h0B00);
    chk("R7 pulse high", 16'(emi_pulse), 16'h1);
    rd(1'b0, v); chk("R5 bit 11 reads 0", v & 16'hF800, 16'h0000);
    chk("R6 power indicator off", 16'(pwr_ind), 16'h3);
    tick(1);
    chk("R7 pulse one cycle", 16'(emi_pulse), 16'h0);
    tick(LAT);
    wr_reg(1'b1, 2'b01, 16'h001F);

    // R11 power fault survives power-off
    wr_reg(1'b0, 2'b01, 16'h0022);
    pf = 1'b1; tick(1);
    rd(1'b1, v); chk("R2 fault latched", v & 16'h0002, 16'h0002);
    chk("R10 fault irq", 16'(irq), 16'h1);
    wr_reg(1'b0, 2'b10, 16'h0700);
    pf = 1'b0; tick(LAT + 2);
    chk("R6 power off", 16'(pwr_en), 16'h0);
    rd(1'b1, v); chk("R11 fault kept", v & 16'h0002, 16'h0002);
    wr_reg(1'b1, 2'b10, 16'h00FF);
    rd(1'b1, v); chk("R4 high lane write ignored", v & 16'h001F, 16'h0012);
    wr_reg(1'b1, 2'b01, 16'h0002);
    rd(1'b1, v); chk("R11 fault cleared by W1C", v & 16'h0002, 16'h0000);
    wr_reg(1'b1, 2'b01, 16'h001F);

    // R3 set beats clear
    btn = 1'b1;
    wr_reg(1'b1, 2'b01, 16'h0001);
    rd(1'b1, v); chk("R3 set wins over clear", v & 16'h0001, 16'h0001);
    btn = 1'b0; tick(1);
    wr_reg(1'b1, 2'b01, 16'h0000);
    rd(1'b1, v); chk("R3 write 0 keeps bit", v & 16'h0001, 16'h0001);
    wr_reg(1'b1, 2'b01, 16'h0001);
    rd(1'b1, v); chk("R2 falling button no event", v & 16'h0001, 16'h0000);

    // R2 latch both directions, R4 live bits
    lat = 1'b1; emi_st = 1'b1; tick(1);
    rd(1'b1, v); chk("R4 live bits", v & 16'hFFE0, 16'h00E0);
    chk("R2 latch rise", v & 16'h0004, 16'h0004);
    wr_reg(1'b1, 2'b01, 16'h0004);
    lat = 1'b0; tick(1);
    rd(1'b1, v); chk("R2 latch fall", v & 16'h0004, 16'h0004);
    prs = 1'b0; tick(1);
    rd(1'b1, v); chk("R2 presence change", v & 16'h0008, 16'h0008);
    wr_reg(1'b1, 2'b01, 16'h001F);

    // constrained random phase
    for (int c = 0; c < 4000; c++) begin
      if ($urandom_range(0, 9) == 0) btn    = ~btn;
      if ($urandom_range(0, 19) == 0) pf    = ~pf;
      if ($urandom_range(0, 14) == 0) lat   = ~lat;
      if ($urandom_range(0, 14) == 0) prs   = ~prs;
      if ($urandom_range(0, 24) == 0) emi_st = ~emi_st;
      reg_wr  = ($urandom_range(0, 5) == 0);
      reg_sel = ($urandom_range(0, 2) != 0);
      reg_be  = 2'($urandom_range(0, 3));
      reg_wd  = 16'($urandom());
      @(posedge clk); @(negedge clk);
      reg_wr = 1'b0;
      compare_all();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule